// File: doc/BRIEF.md
# Dual-Mode Page Table Walker

This block turns a virtual address into a physical address by reading page-table entries from memory, one level at a time. A caller presents the virtual address, a mode bit and the root table base. The mode bit selects either a two-level walk with 4-byte entries, which matches the 32-bit layout without address extension, or a four-level walk with 8-byte entries for long mode. Only 4 KB pages are handled.

Every level makes one read on a simple request/valid memory port. The read returns an entry. A set present bit in that entry supplies the base of the next table, or the base of the final page. The walk ends with a single done pulse. That pulse carries either the physical address or a fault status that names the level where the walk stopped. Only one walk is in flight at a time.

Top module: `ptw_top`

## Requirements
- R1: Reset is synchronous and active high. While it is asserted and after it is released, `busy`, `done` and `mem_req` are low until a request is accepted.
- R2: When `req_long`=0, the walk has two reads. The first read is at root[31:12]·4096 + va[31:22]·4. The second is at entry[31:12]·4096 + va[21:12]·4. Entry bits 63:32, va bits 63:32 and root bits 51:32 are ignored, and no canonical check is made.
- R3: When `req_long`=1, the walk has four reads. Each read is at the table base + index·8. The index is va[47:39] for the first read, then va[38:30], then va[29:21], then va[20:12]. The first table base is root[51:12]·4096. Each later base is entry[51:12]·4096.
- R4: On success the result is `done_status`=0, `done_level`=0 and `done_paddr` = last entry frame·4096 | va[11:0]. The frame is entry[51:12] in long mode and entry[31:12] in 32-bit mode, and the upper bits are zero in 32-bit mode. Entry bits 63:52 are ignored.
- R5: Entry bit 0 is the present flag. A clear present bit ends the walk with no further reads. The result is `done_status`=1 and `done_level` = the level of that entry. Levels count down to 0 at the last table: 3,2,1,0 in long mode and 1,0 in 32-bit mode.
- R6: A long-mode address whose bits 63:48 are not all equal to bit 47 makes no read. `done` rises in the cycle after acceptance, with `done_status`=2, `done_level`=3 and `done_paddr`=0.
- R7: A request is accepted only while `busy` is low. `busy` is high from the cycle after acceptance until the cycle of `done`. A `req_valid` seen while busy is ignored.
- R8: Each read waits for `mem_rvalid` before the walk moves on, whatever the latency. An `mem_rvalid` that arrives while no read is outstanding has no effect.
- R9: `mem_req` is a one-cycle pulse, and at most one read is outstanding.
- R10: `done` is a one-cycle pulse for each accepted request, and `busy` is low while it is high. A new request may be accepted in the same cycle as `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_long | input | 1 | 1 = four-level long mode, 0 = two-level 32-bit mode |
| req_vaddr | input | 64 | Virtual address to translate |
| req_root | input | 52 | Physical base of the top table (bits 11:0 ignored) |
| busy | output | 1 | A walk is in progress |
| mem_req | output | 1 | Entry read request pulse |
| mem_addr | output | 52 | Byte address of the entry read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Entry read data (bits 31:0 used in 32-bit mode) |
| done | output | 1 | Walk result pulse |
| done_status | output | 2 | 0 = ok, 1 = entry not present, 2 = non-canonical address |
| done_level | output | 2 | Level at which the walk stopped |
| done_paddr | output | 52 | Translated physical address, valid when status is 0 |

## Verification
The two functions that can fall in the same cycle are the `done` pulse of one walk and the acceptance of the next request. The driver keeps the next request waiting and raises `req_valid` in the very cycle in which `busy` drops and `done` is high. The scoreboard then expects the first result unchanged, followed by an exact read-address sequence for the following walk. Back-to-back non-canonical requests push this further, because they produce `done` in two consecutive cycles and each must match its own queued item. A stray `mem_rvalid` while idle, and requests raised during a walk, are judged at the ports: the bench sees no extra done and the next result is correct.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int VA_W         = 64;
    localparam int PA_W         = 52;
    localparam int ENT_W        = 64;
    localparam int PG_SHIFT     = 12;
    localparam int LM_IDX_W     = 9;
    localparam int LG_IDX_W     = 10;
    localparam int LM_LEVELS    = 4;
    localparam int LG_LEVELS    = 2;
    localparam int LM_ENT_SHIFT = 3;   // 8-byte entries
    localparam int LG_ENT_SHIFT = 2;   // 4-byte entries
    localparam int LG_ENT_W     = 32;
    localparam int LVL_W        = 2;
    localparam int CANON_BIT    = PG_SHIFT + LM_LEVELS * LM_IDX_W - 1;

    typedef enum logic [1:0] {
        ST_OK          = 2'd0,
        ST_NOT_PRESENT = 2'd1,
        ST_NONCANON    = 2'd2
    } walk_status_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_WAIT  = 2'd2
    } walk_state_e;

    typedef struct packed {
        logic             long_mode;
        logic [VA_W-1:0]  vaddr;
        logic [PA_W-1:0]  base;
        logic [LVL_W-1:0] level;
    } walk_ctx_t;

    function automatic logic is_canonical(input logic [VA_W-1:0] va);
        return (va[VA_W-1:CANON_BIT] == '0) || (&va[VA_W-1:CANON_BIT]);
    endfunction
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  logic             long_mode,
    input  logic [LVL_W-1:0] level,
    input  logic [VA_W-1:0]  vaddr,
    input  logic [PA_W-1:0]  base,
    output logic [PA_W-1:0]  entry_addr
);
    logic [LM_IDX_W-1:0] lm_idx [LM_LEVELS];
    logic [LG_IDX_W-1:0] lg_idx [LG_LEVELS];

    for (genvar g = 0; g < LM_LEVELS; g++) begin : g_lm_slice
        assign lm_idx[g] = vaddr[PG_SHIFT + g*LM_IDX_W +: LM_IDX_W];
    end
    for (genvar g = 0; g < LG_LEVELS; g++) begin : g_lg_slice
        assign lg_idx[g] = vaddr[PG_SHIFT + g*LG_IDX_W +: LG_IDX_W];
    end

    always_comb begin
        if (long_mode)
            entry_addr = base + (PA_W'(lm_idx[level]) << LM_ENT_SHIFT);
        else
            entry_addr = base + (PA_W'(lg_idx[level[0]]) << LG_ENT_SHIFT);
    end

    logic unused_va;
    assign unused_va = ^{vaddr[VA_W-1:CANON_BIT+1], vaddr[PG_SHIFT-1:0]};
endmodule

// File: rtl/ptw_entry_dec.sv
module ptw_entry_dec
    import ptw_pkg::*;
(
    input  logic             long_mode,
    input  logic [ENT_W-1:0] rdata,
    output logic             present,
    output logic [PA_W-1:0]  frame_base
);
    always_comb begin
        present = rdata[0];
        if (long_mode)
            frame_base = {rdata[PA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
        else
            frame_base = PA_W'({rdata[LG_ENT_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}});
    end

    logic unused_bits;
    assign unused_bits = ^{rdata[ENT_W-1:PA_W], rdata[PG_SHIFT-1:1]};
endmodule

// File: rtl/ptw_top.sv
module ptw_top
    import ptw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_long,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [PA_W-1:0]  req_root,
    output logic             busy,
    output logic             mem_req,
    output logic [PA_W-1:0]  mem_addr,
    input  logic             mem_rvalid,
    input  logic [ENT_W-1:0] mem_rdata,
    output logic             done,
    output logic [1:0]       done_status,
    output logic [LVL_W-1:0] done_level,
    output logic [PA_W-1:0]  done_paddr
);
    localparam logic [LVL_W-1:0] LM_TOP = LVL_W'(LM_LEVELS - 1);
    localparam logic [LVL_W-1:0] LG_TOP = LVL_W'(LG_LEVELS - 1);
    localparam logic [PA_W-1:0]  LG_MASK = PA_W'({LG_ENT_W{1'b1}});

    walk_state_e  state;
    walk_ctx_t    ctx;
    walk_status_e status_q;
    logic         ent_present;
    logic [PA_W-1:0] frame_base;
    logic [PA_W-1:0] root_base;

    assign root_base = {req_root[PA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};

    ptw_addr_gen u_addr_gen (
        .long_mode (ctx.long_mode),
        .level     (ctx.level),
        .vaddr     (ctx.vaddr),
        .base      (ctx.base),
        .entry_addr(mem_addr)
    );

    ptw_entry_dec u_entry_dec (
        .long_mode (ctx.long_mode),
        .rdata     (mem_rdata),
        .present   (ent_present),
        .frame_base(frame_base)
    );

    assign busy        = (state != S_IDLE);
    assign mem_req     = (state == S_ISSUE);
    assign done_status = status_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            ctx        <= '0;
            done       <= 1'b0;
            status_q   <= ST_OK;
            done_level <= '0;
            done_paddr <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        ctx.long_mode <= req_long;
                        ctx.vaddr     <= req_vaddr;
                        ctx.base      <= req_long ? root_base : (root_base & LG_MASK);
                        ctx.level     <= req_long ? LM_TOP : LG_TOP;
                        if (req_long && !is_canonical(req_vaddr)) begin
                            done       <= 1'b1;
                            status_q   <= ST_NONCANON;
                            done_level <= LM_TOP;
                            done_paddr <= '0;
                        end else begin
                            state <= S_ISSUE;
                        end
                    end
                end
                S_ISSUE: state <= S_WAIT;
                S_WAIT: begin
                    if (mem_rvalid) begin
                        if (!ent_present) begin
                            done       <= 1'b1;
                            status_q   <= ST_NOT_PRESENT;
                            done_level <= ctx.level;
                            done_paddr <= '0;
                            state      <= S_IDLE;
                        end else if (ctx.level == '0) begin
                            done       <= 1'b1;
                            status_q   <= ST_OK;
                            done_level <= '0;
                            done_paddr <= frame_base | PA_W'(ctx.vaddr[PG_SHIFT-1:0]);
                            state      <= S_IDLE;
                        end else begin
                            ctx.base  <= frame_base;
                            ctx.level <= ctx.level - 1'b1;
                            state     <= S_ISSUE;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    logic unused_root;
    assign unused_root = ^req_root[PG_SHIFT-1:0];

    // R9: a read request never repeats in the next cycle
    a_r9_single_read: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);
    // R7: reads only happen inside a busy walk
    a_r7_req_in_walk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);
    // R10: the result pulse is seen only when idle
    a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !mem_req));
    // R6: non-canonical faults report the top level and no address
    a_r6_noncanon_level: assert property (@(posedge clk) disable iff (rst)
        (done && done_status == ST_NONCANON) |-> (done_level == LM_TOP && done_paddr == '0));
    // R8: without read data the walk holds its place
    a_r8_wait_hold: assert property (@(posedge clk) disable iff (rst)
        (state == S_WAIT && !mem_rvalid) |=> (state == S_WAIT && $stable(ctx)));
    // R2: 32-bit walks never address above 4 GB
    a_r2_addr32: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !ctx.long_mode) |-> (mem_addr[PA_W-1:LG_ENT_W] == '0));
    // R4: a translated address keeps the page offset
    a_r4_offset: assert property (@(posedge clk) disable iff (rst)
        (done && done_status == ST_OK) |-> (done_paddr[PG_SHIFT-1:0] == ctx.vaddr[PG_SHIFT-1:0]));
endmodule

// File: tb/ptw_top_tb.sv
module ptw_top_tb;
    import ptw_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 4 time-unit period, 250 MHz at 1 ns

    logic        rst, req_valid, req_long;
    logic [63:0] req_vaddr;
    logic [51:0] req_root;
    logic        busy, mem_req, mem_rvalid, done;
    logic [51:0] mem_addr, done_paddr;
    logic [63:0] mem_rdata;
    logic [1:0]  done_status, done_level;

    ptw_top u_dut (.*);

    typedef struct {
        logic [1:0]  st;
        logic [1:0]  lvl;
        logic [51:0] pa;
        int          nreads;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    logic [51:0] addr_q[$];
    logic [63:0] mem [logic [51:0]];
    int n_cmp = 0, n_bad = 0, reads_seen = 0, lat_sel = 0;
    bit stray_req = 1'b0;

    function automatic void check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // memory responder: variable latency, checks each read address (R2/R3/R8)
    initial begin
        mem_rvalid = 1'b0;
        mem_rdata  = '0;
        forever begin
            logic [51:0] a;
            logic [51:0] e;
            int lat;
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (mem_req) begin
                a = mem_addr;
                lat = 1 + (lat_sel % 4);
                lat_sel++;
                if (addr_q.size() == 0) check(1'b0, "R9", "unexpected read", 64'(a), 64'h0);
                else begin
                    e = addr_q.pop_front();
                    check(a == e, "R2/R3", "read address", 64'(a), 64'(e));
                end
                repeat (lat) @(negedge clk);
                mem_rvalid = 1'b1;
                mem_rdata  = mem.exists(a) ? mem[a] : 64'h0;
            end else if (stray_req) begin
                mem_rvalid = 1'b1;           // R8: stray data while idle
                mem_rdata  = 64'hFFFF_FFFF_FFFF_FFFF;
                stray_req  = 1'b0;
            end
        end
    end

    // monitor / scoreboard
    initial begin
        forever begin
            exp_t e;
            @(negedge clk);
            if (!rst) begin
                if (mem_req) reads_seen++;
                if (done) begin
                    check(!busy, "R10", "busy during done", 64'(busy), 64'h0);
                    if (exp_q.size() == 0) check(1'b0, "R10", "unexpected done", 64'h1, 64'h0);
                    else begin
                        e = exp_q.pop_front();
                        check(done_status == e.st, e.tag, "status", 64'(done_status), 64'(e.st));
                        check(done_level == e.lvl, e.tag, "level", 64'(done_level), 64'(e.lvl));
                        if (e.st == 2'd0)
                            check(done_paddr == e.pa, e.tag, "paddr", 64'(done_paddr), 64'(e.pa));
                        check(reads_seen == e.nreads, e.tag, "read count", 64'(reads_seen), 64'(e.nreads));
                    end
                    reads_seen = 0;
                end
            end
        end
    end

    task automatic send(input bit lm, input logic [63:0] va, input logic [51:0] root);
        while (busy) @(negedge clk);
        req_valid = 1'b1; req_long = lm; req_vaddr = va; req_root = root;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic walk(input bit lm, input logic [63:0] va, input logic [51:0] root,
                        input int np_lvl, input logic [39:0] seed, input string tag);
        logic [51:0] base, a;
        logic [39:0] fr;
        logic [63:0] ent;
        exp_t e;
        while (busy) @(negedge clk);
        base = lm ? {root[51:12], 12'h0} : {20'h0, root[31:12], 12'h0};
        e.st = 2'd0; e.lvl = 2'd0; e.pa = '0; e.nreads = 0; e.tag = tag;
        for (int l = (lm ? 3 : 1); l >= 0; l--) begin
            if (lm) a = base + {40'h0, va[12 + 9*l +: 9], 3'b000};
            else    a = base + {40'h0, (l == 1 ? va[31:22] : va[21:12]), 2'b00};
            addr_q.push_back(a);
            e.nreads++;
            fr = seed + 40'(l) * 40'h1357;
            if (lm) ent = {12'hFA5, fr, 11'h5A5, (l != np_lvl)};
            else    ent = {32'hC3C3_C3C3, fr[19:0], 11'h5A5, (l != np_lvl)};
            mem[a] = ent;
            if (l == np_lvl) begin
                e.st = 2'd1; e.lvl = 2'(l);
                break;
            end
            base = lm ? {fr, 12'h0} : {20'h0, fr[19:0], 12'h0};
        end
        if (e.st == 2'd0) e.pa = base | {40'h0, va[11:0]};
        exp_q.push_back(e);
        send(lm, va, root);
    endtask

    task automatic noncanon(input logic [63:0] va, input string tag);
        exp_t e;
        while (busy) @(negedge clk);
        e.st = 2'd2; e.lvl = 2'd3; e.pa = '0; e.nreads = 0; e.tag = tag;
        exp_q.push_back(e);
        send(1'b1, va, 52'h0_0000_0010_0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_long = 1'b0; req_vaddr = '0; req_root = '0;
        repeat (3) @(negedge clk);
        check(!busy && !done && !mem_req, "R1", "outputs in reset", {busy, done, mem_req}, 64'h0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !mem_req, "R1", "outputs after reset", {busy, done, mem_req}, 64'h0);

        // R2 / R4: 32-bit walks, junk upper bits in va, root and entries
        walk(1'b0, 64'hDEAD_BEEF_F72C_5C00, 52'hF_FFFF_0A07_D123, -1, 40'h01014, "R2");
        walk(1'b0, 64'h1234_5678_0040_3FFF, 52'h0_0000_0001_0000, -1, 40'hFFFFF, "R4");
        // R5: not-present at each 32-bit level
        walk(1'b0, 64'h0000_0000_8040_1ABC, 52'h0_0000_0002_0000, 1, 40'h00333, "R5");
        walk(1'b0, 64'h0000_0000_8040_1ABC, 52'h0_0000_0002_0000, 0, 40'h00444, "R5");
        // R3 / R4: long-mode walks, both halves of the canonical space
        walk(1'b1, 64'hFFFF_FADE_C24E_B7C0, 52'h0_0000_0014_7000, -1, 40'h01_1180_0000, "R3");
        walk(1'b1, 64'h0000_7FFF_FFFF_FFFF, 52'hF_0000_0000_0ABC, -1, 40'hFF_FFFF_0000, "R4");
        walk(1'b1, 64'hFFFF_8000_0000_0000, 52'h0_0000_0030_0000, -1, 40'h00_0000_1000, "R3");
        // R5: not-present at each long-mode level
        for (int l = 3; l >= 0; l--)
            walk(1'b1, 64'h0000_1234_5678_9ABC, 52'h0_0000_0040_0000, l, 40'h55_0000_0000 + 40'(l), "R5");
        // R6: non-canonical addresses, back to back (done in consecutive cycles)
        noncanon(64'h0000_8000_0000_0000, "R6");
        noncanon(64'h0001_0000_0000_0000, "R6");
        noncanon(64'hFFFE_FFFF_FFFF_F000, "R6");
        // R7: requests raised during a walk are ignored
        walk(1'b1, 64'h0000_0042_1357_9000, 52'h0_0000_0050_0000, -1, 40'h12_3456_7000, "R7");
        req_valid = 1'b1; req_long = 1'b1; req_vaddr = 64'h0001_0000_0000_0000;
        for (int i = 0; i < 3; i++) begin
            check(busy, "R7", "busy during walk", 64'(busy), 64'h1);
            @(negedge clk);
        end
        req_valid = 1'b0;
        // R8: stray read data while idle has no effect
        while (busy || exp_q.size() != 0) @(negedge clk);
        stray_req = 1'b1;
        repeat (4) @(negedge clk);
        check(!busy && !done, "R8", "stray data ignored", {busy, done}, 64'h0);
        walk(1'b0, 64'h0000_0000_C030_0F70, 52'h0_0000_0006_0000, -1, 40'h06CE7, "R8");
        // R10: long walk directly followed by a 32-bit walk (accept in done cycle)
        walk(1'b1, 64'hFFFF_F6FB_7DBE_DFA8, 52'h0_0000_0070_0000, -1, 40'h0A_BCDE_F000, "R10");
        walk(1'b0, 64'h0000_0000_0000_0FFF, 52'h0_0000_0008_0000, -1, 40'h00777, "R10");

        while (busy || exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        check(addr_q.size() == 0, "R9", "reads left over", 64'(addr_q.size()), 64'h0);
        summary();
    end
endmodule